// File: doc/BRIEF.md
# Interrupt Status and Mask Register Block with Broadcast Writes

This block sits inside one cache of a multiprocessor and holds that cache's interrupt state. It has three registers: a status word whose bits are posted by software, a mask word that chooses which posted bits the processor cares about, and a read-only identifier that returns the cache's own bus number. Status bits are set through one register offset and cleared through another, so posting and acknowledging interrupts never needs a read-modify-write.

Requests arrive on a plain I/O port that carries an address, write data, write and read strobes, a self-access flag and a broadcast flag. A request reaches the registers in one of three ways. It can be directed to this cache by its device number. It can be a self access from the attached processor, where the address holds only the register offset. Or it can be a broadcast write that every cache accepts. Whenever an operation makes an interrupt visible that was not visible before, the block raises a one-clock reschedule pulse toward the processor. An interrupt is visible when its status bit and its mask bit are both set.

Top module: `irq_bcast_regs`

## Requirements
- R1: A write to offset 0 ORs the write data into the status word, and status bits that are already 1 stay 1.
- R2: A write to offset 1 clears each status bit whose write-data bit is 1 and leaves the others alone. A read of offset 1 returns zero.
- R3: `resched_o` is high for the single cycle after a write exactly when (new status AND new mask) has a 1 where (old status AND old mask) had a 0. Writes to either the status or the mask can cause it.
- R4: Offset 2 is the mask, which can be read and written. Offset 3 returns the `bus_id_i` value zero-extended, and writes to it are ignored. Every other offset reads as zero, and writes to it change nothing.
- R5: A directed access uses address = BASE_ADDR + 1024 × device + offset. The device sits in bits [19:10], the offset in bits [7:0], and bits [9:8] must be zero. Bits [31:20] must equal those of BASE_ADDR. The block accepts it only when the device equals `bus_id_i`. Any other device number, nonzero bits in [9:8], or a wrong base makes no change and reads zero.
- R6: A write with `bcast_i`=1 and device number 1023 (all ones) is accepted as if it were addressed to this cache. Device 1023 with `bcast_i`=0 is ignored.
- R7: A read to device 1023 returns zero and changes no state.
- R8: With `self_i`=1, bits [7:0] of the address select the register, the rest of the address is ignored, and the request always reaches this block.
- R9: Read data appears on `rdata_o` in the cycle after `rd_en_i` and is zero in every other cycle. When `wr_en_i` and `rd_en_i` are both high, the write is performed and the read returns zero.
- R10: While reset is asserted and after it is released, status, mask, `rdata_o` and `resched_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| arst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_id_i | input | DEV_W | This cache's device number on the bus |
| addr_i | input | ADDR_W | Request address |
| wdata_i | input | DATA_W | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| self_i | input | 1 | Request comes from the attached processor with an offset-only address |
| bcast_i | input | 1 | Request is a broadcast to all caches |
| rdata_o | output | DATA_W | Read data, valid the cycle after a read |
| resched_o | output | 1 | One-cycle pulse when a new interrupt becomes visible |

## Verification
The bench builds the block with BASE_ADDR = 0x0030_0000 and a device number of 5. The nonzero base means that an address with the right device field but the wrong upper bits has to be rejected. The small device number lets the bench send directed traffic to a neighbouring device, and broadcasts to device 1023 both with and without the broadcast flag. Data and offset widths stay at their defaults of 32 and 8. With those widths, the pad bits [9:8] can be set to reach an unused slot, and mask patterns can put visible bits in both the low and the upper bytes.

// File: rtl/irq_bcast_pkg.sv
package irq_bcast_pkg;

  // Register offsets; the decode and the software view both depend on these.
  localparam int unsigned OFF_STATUS = 0;
  localparam int unsigned OFF_CLEAR  = 1;
  localparam int unsigned OFF_MASK   = 2;
  localparam int unsigned OFF_ID     = 3;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_MASK   = 2'd2,
    SEL_ID     = 2'd3
  } rd_sel_e;

  typedef struct packed {
    logic set_wr;
    logic clr_wr;
    logic mask_wr;
  } wr_cmd_t;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import irq_bcast_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 8,
  parameter int unsigned SLOT_W = 10,
  parameter int unsigned DEV_W  = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic              self_i,
  input  logic              bcast_i,
  input  logic [DEV_W-1:0]  bus_id_i,
  output wr_cmd_t           wr_cmd_o,
  output rd_sel_e           rd_sel_o
);

  localparam int unsigned TOP_LSB = SLOT_W + DEV_W;
  localparam logic [DEV_W-1:0] BCAST_DEV = {DEV_W{1'b1}};

  logic [OFF_W-1:0] off;
  logic [DEV_W-1:0] dev;
  logic             base_ok;
  logic             pad_ok;
  logic             directed;
  logic             bc_write;
  logic             take_wr;
  logic             take_rd;

  assign off     = addr_i[OFF_W-1:0];
  assign dev     = addr_i[TOP_LSB-1:SLOT_W];
  assign base_ok = (addr_i[ADDR_W-1:TOP_LSB] == BASE_ADDR[ADDR_W-1:TOP_LSB]);

  generate
    if (SLOT_W > OFF_W) begin : g_pad
      assign pad_ok = (addr_i[SLOT_W-1:OFF_W] == '0);
    end else begin : g_nopad
      assign pad_ok = 1'b1;
    end
  endgenerate

  assign directed = base_ok & pad_ok & (dev == bus_id_i);
  assign bc_write = bcast_i & base_ok & pad_ok & (dev == BCAST_DEV);

  assign take_wr = wr_en_i & (self_i | directed | bc_write);
  assign take_rd = rd_en_i & ~wr_en_i & (self_i | directed);

  always_comb begin
    wr_cmd_o.set_wr  = take_wr & (off == OFF_W'(OFF_STATUS));
    wr_cmd_o.clr_wr  = take_wr & (off == OFF_W'(OFF_CLEAR));
    wr_cmd_o.mask_wr = take_wr & (off == OFF_W'(OFF_MASK));
  end

  always_comb begin
    rd_sel_o = SEL_NONE;
    if (take_rd) begin
      if (off == OFF_W'(OFF_STATUS)) begin
        rd_sel_o = SEL_STATUS;
      end else if (off == OFF_W'(OFF_MASK)) begin
        rd_sel_o = SEL_MASK;
      end else if (off == OFF_W'(OFF_ID)) begin
        rd_sel_o = SEL_ID;
      end
    end
  end

endmodule

// File: rtl/irq_state_regs.sv
module irq_state_regs
  import irq_bcast_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  wr_cmd_t           wr_cmd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] status_q,
  output logic [DATA_W-1:0] mask_q,
  output logic              resched_q
);

  logic [DATA_W-1:0] status_d;
  logic [DATA_W-1:0] mask_d;
  logic [DATA_W-1:0] vis_old;
  logic [DATA_W-1:0] vis_new;
  logic              status_en;
  logic              mask_en;
  logic              resched_d;

  // Per-bit status cell: clear has its own offset, set its own, never both.
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    always_comb begin
      if (wr_cmd_i.clr_wr) begin
        status_d[b] = status_q[b] & ~wdata_i[b];
      end else if (wr_cmd_i.set_wr) begin
        status_d[b] = status_q[b] | wdata_i[b];
      end else begin
        status_d[b] = status_q[b];
      end
    end
  end

  always_comb begin
    status_en = wr_cmd_i.set_wr | wr_cmd_i.clr_wr;
    mask_en   = wr_cmd_i.mask_wr;
    mask_d    = mask_en ? wdata_i : mask_q;
    vis_old   = status_q & mask_q;
    vis_new   = status_d & mask_d;
    resched_d = |(vis_new & ~vis_old);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
    end else if (status_en) begin
      status_q <= status_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resched_q <= 1'b0;
    end else begin
      resched_q <= resched_d;
    end
  end

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_bcast_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEV_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  rd_sel_e           rd_sel_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [DEV_W-1:0]  bus_id_i,
  output logic [DATA_W-1:0] rdata_q
);

  localparam int unsigned ID_PAD = DATA_W - DEV_W;

  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    unique case (rd_sel_i)
      SEL_STATUS: rdata_d = status_i;
      SEL_MASK:   rdata_d = mask_i;
      SEL_ID:     rdata_d = {{ID_PAD{1'b0}}, bus_id_i};
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

endmodule

// File: rtl/irq_bcast_regs.sv
module irq_bcast_regs
  import irq_bcast_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 8,
  parameter int unsigned SLOT_W = 10,
  parameter int unsigned DEV_W  = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              arst_ni,
  input  logic [DEV_W-1:0]  bus_id_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic              self_i,
  input  logic              bcast_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              resched_o
);

  logic              rst_n;
  wr_cmd_t           wr_cmd;
  rd_sel_e           rd_sel;
  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] mask_q;

  irq_rst_sync u_rst_sync (
    .clk_i   (clk_i),
    .arst_ni (arst_ni),
    .rst_no  (rst_n)
  );

  irq_addr_decode #(
    .ADDR_W    (ADDR_W),
    .OFF_W     (OFF_W),
    .SLOT_W    (SLOT_W),
    .DEV_W     (DEV_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_decode (
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .self_i   (self_i),
    .bcast_i  (bcast_i),
    .bus_id_i (bus_id_i),
    .wr_cmd_o (wr_cmd),
    .rd_sel_o (rd_sel)
  );

  irq_state_regs #(
    .DATA_W (DATA_W)
  ) u_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .wr_cmd_i  (wr_cmd),
    .wdata_i   (wdata_i),
    .status_q  (status_q),
    .mask_q    (mask_q),
    .resched_q (resched_o)
  );

  irq_read_mux #(
    .DATA_W (DATA_W),
    .DEV_W  (DEV_W)
  ) u_rmux (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .rd_sel_i (rd_sel),
    .status_i (status_q),
    .mask_i   (mask_q),
    .bus_id_i (bus_id_i),
    .rdata_q  (rdata_o)
  );

endmodule

// File: rtl/irq_bcast_regs_chk.sv
module irq_bcast_regs_chk
  import irq_bcast_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_n,
  input wr_cmd_t           wr_cmd,
  input rd_sel_e           rd_sel,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] status_q,
  input logic [DATA_W-1:0] mask_q,
  input logic              resched_o,
  input logic [DATA_W-1:0] rdata_o
);

  // R1: a set write leaves every written bit at 1
  p_set_bits_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    wr_cmd.set_wr |=> ((status_q & $past(wdata_i)) == $past(wdata_i)));

  // R1: without a clear, no status bit falls
  p_sticky_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    !wr_cmd.clr_wr |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R2: a clear write leaves every written bit at 0
  p_clear_bits_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    wr_cmd.clr_wr |=> ((status_q & $past(wdata_i)) == '0));

  // R3: a pulse only with a newly visible bit
  p_resched_new_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    resched_o |-> ((status_q & mask_q & ~$past(status_q & mask_q)) != '0));

  // R3: every newly visible bit gives a pulse
  p_resched_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((status_q & mask_q & ~$past(status_q & mask_q)) != '0) |-> resched_o);

  // R4: the mask changes only through its own offset
  p_mask_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    !wr_cmd.mask_wr |=> (mask_q == $past(mask_q)));

  // R9: no accepted read, zero read data next cycle
  p_rd_none_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_sel == SEL_NONE) |=> (rdata_o == '0));

endmodule

bind irq_bcast_regs irq_bcast_regs_chk #(
  .DATA_W (DATA_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_n     (rst_n),
  .wr_cmd    (wr_cmd),
  .rd_sel    (rd_sel),
  .wdata_i   (wdata_i),
  .status_q  (status_q),
  .mask_q    (mask_q),
  .resched_o (resched_o),
  .rdata_o   (rdata_o)
);

// File: tb/irq_bcast_regs_bench.sv
`timescale 1ns/1ps
module irq_bcast_regs_bench;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DEV_W  = 10;
  localparam logic [31:0] BASE   = 32'h0030_0000;
  localparam logic [9:0]  MY_ID  = 10'd5;
  localparam logic [9:0]  BC_ID  = 10'd1023;

  logic              clk = 1'b0;
  logic              arst_n = 1'b0;
  logic [31:0]       addr = '0;
  logic [31:0]       wdata = '0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic              self_f = 1'b0;
  logic              bc_f = 1'b0;
  logic [31:0]       rdata;
  logic              resched;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [31:0] m_status = '0;
  logic [31:0] m_mask = '0;

  int          due_q[$];
  logic [31:0] rd_q[$];
  bit          rs_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  irq_bcast_regs #(
    .DATA_W (DATA_W), .ADDR_W (ADDR_W), .OFF_W (8), .SLOT_W (10),
    .DEV_W (DEV_W), .BASE_ADDR (BASE)
  ) u_irq_bcast_regs (
    .clk_i (clk), .arst_ni (arst_n), .bus_id_i (MY_ID), .addr_i (addr),
    .wdata_i (wdata), .wr_en_i (wr_en), .rd_en_i (rd_en), .self_i (self_f),
    .bcast_i (bc_f), .rdata_o (rdata), .resched_o (resched)
  );

  function automatic logic [31:0] dir_addr(input logic [9:0] dev, input logic [7:0] off);
    return BASE + {12'd0, dev, 10'd0} + {24'd0, off};
  endfunction

  task automatic check(input string tag, input logic [31:0] got_rd, input logic [31:0] exp_rd,
                       input bit got_rs, input bit exp_rs);
    compared++;
    if (got_rd !== exp_rd || got_rs !== exp_rs) begin
      mismatched++;
      $display("FAIL %s: rdata=%h exp=%h resched=%b exp=%b", tag, got_rd, exp_rd, got_rs, exp_rs);
    end
  endtask

  // Monitor: pops each expected item in the cycle its result is due.
  always @(negedge clk) begin
    if (due_q.size() > 0 && due_q[0] == cyc) begin
      check(tag_q[0], rdata, rd_q[0], resched, rs_q[0]);
      void'(due_q.pop_front());
      void'(rd_q.pop_front());
      void'(rs_q.pop_front());
      void'(tag_q.pop_front());
    end
  end

  // Driver: called at a negedge; drives one request, predicts, pushes, advances.
  task automatic req(input bit wr, input bit rd, input bit sf, input bit bc,
                     input logic [31:0] a, input logic [31:0] d, input string tag);
    logic [7:0]  off;
    logic [9:0]  dev;
    bit          loc;
    bit          hit_w;
    bit          hit_r;
    logic [31:0] exp_rd;
    logic [31:0] n_status;
    logic [31:0] n_mask;
    addr = a; wdata = d; wr_en = wr; rd_en = rd; self_f = sf; bc_f = bc;
    off = a[7:0];
    dev = a[19:10];
    loc = (a[31:20] == BASE[31:20]) && (a[9:8] == 2'b00);
    hit_w = wr && (sf || (loc && (dev == MY_ID || (bc && dev == BC_ID))));
    hit_r = rd && !wr && (sf || (loc && dev == MY_ID));
    exp_rd = '0;
    if (hit_r) begin
      case (off)
        8'd0: exp_rd = m_status;
        8'd2: exp_rd = m_mask;
        8'd3: exp_rd = {22'd0, MY_ID};
        default: exp_rd = '0;
      endcase
    end
    n_status = m_status;
    n_mask = m_mask;
    if (hit_w) begin
      if (off == 8'd0) n_status = m_status | d;
      if (off == 8'd1) n_status = m_status & ~d;
      if (off == 8'd2) n_mask = d;
    end
    due_q.push_back(cyc + 1);
    rd_q.push_back(exp_rd);
    rs_q.push_back(((n_status & n_mask) & ~(m_status & m_mask)) != '0);
    tag_q.push_back(tag);
    m_status = n_status;
    m_mask = n_mask;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; self_f = 1'b0; bc_f = 1'b0;
  endtask

  task automatic idle(input string tag);
    req(1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 during reset", rdata, 32'h0, resched, 1'b0);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 after release", rdata, 32'h0, resched, 1'b0);

    req(0, 1, 1, 0, 32'h0, 0, "R10 status after reset");
    req(0, 1, 1, 0, 32'h2, 0, "R10 mask after reset");
    req(1, 0, 0, 0, dir_addr(MY_ID, 0), 32'h0000_00F0, "R1 set masked-off");
    req(0, 1, 0, 0, dir_addr(MY_ID, 0), 0, "R1 read status");
    req(1, 0, 0, 0, dir_addr(MY_ID, 0), 32'h0000_001F, "R1 OR keeps set bits");
    req(0, 1, 0, 0, dir_addr(MY_ID, 0), 0, "R1 read OR result");
    req(1, 0, 0, 0, dir_addr(MY_ID, 2), 32'h0000_0030, "R3 mask makes visible");
    req(0, 1, 0, 0, dir_addr(MY_ID, 2), 0, "R4 read mask");
    req(1, 0, 0, 0, dir_addr(MY_ID, 2), 32'h0000_0030, "R3 same mask no pulse");
    req(1, 0, 0, 0, dir_addr(MY_ID, 0), 32'h0000_0010, "R3 set already visible");
    req(1, 0, 0, 0, dir_addr(MY_ID, 2), 32'h8000_0130, "R3 mask adds unset bits");
    req(1, 0, 1, 0, 32'hFFFF_FF00, 32'h0000_0100, "R8 self set with junk upper bits");
    req(0, 1, 1, 0, 32'h1234_5600, 0, "R8 self read status");
    req(1, 0, 0, 0, dir_addr(MY_ID, 1), 32'h0000_000F, "R2 clear low nibble");
    req(0, 1, 0, 0, dir_addr(MY_ID, 0), 0, "R2 read after clear");
    req(0, 1, 0, 0, dir_addr(MY_ID, 1), 0, "R2 clear offset reads zero");
    req(1, 0, 0, 0, dir_addr(MY_ID, 1), 32'h0000_0100, "R2 clear visible bit");
    req(1, 0, 0, 0, dir_addr(MY_ID, 0), 32'h0000_0100, "R3 re-set gives pulse");
    idle("R3 pulse lasts one cycle");
    req(1, 0, 0, 1, dir_addr(BC_ID, 0), 32'h8000_0000, "R6 broadcast set");
    req(0, 1, 0, 0, dir_addr(MY_ID, 0), 0, "R6 read after broadcast");
    req(1, 0, 0, 0, dir_addr(BC_ID, 0), 32'h0000_0200, "R6 dev 1023 without flag");
    req(1, 0, 0, 1, dir_addr(BC_ID, 1), 32'h0000_0010, "R6 broadcast clear");
    req(0, 1, 0, 0, dir_addr(MY_ID, 0), 0, "R6 read after broadcast clear");
    req(0, 1, 0, 1, dir_addr(BC_ID, 0), 0, "R7 broadcast read zero");
    req(0, 1, 0, 0, dir_addr(BC_ID, 2), 0, "R7 dev 1023 read zero");
    req(1, 0, 0, 0, dir_addr(10'd7, 0), 32'h0000_0400, "R5 other device ignored");
    req(0, 1, 0, 0, dir_addr(10'd7, 0), 0, "R5 other device read zero");
    req(1, 0, 0, 0, dir_addr(MY_ID, 0) ^ 32'h0100_0000, 32'h0000_0800, "R5 wrong base ignored");
    req(1, 0, 0, 0, dir_addr(MY_ID, 0) | 32'h0000_0100, 32'h0000_1000, "R5 pad bits ignored");
    req(0, 1, 0, 0, dir_addr(MY_ID, 0), 0, "R5 state unchanged");
    req(0, 1, 0, 0, dir_addr(MY_ID, 3), 0, "R4 id read");
    req(1, 0, 0, 0, dir_addr(MY_ID, 3), 32'hFFFF_FFFF, "R4 id write ignored");
    req(0, 1, 1, 0, 32'h3, 0, "R4 id self read");
    req(1, 0, 0, 0, dir_addr(MY_ID, 9), 32'h0000_2000, "R4 unused offset write");
    req(0, 1, 0, 0, dir_addr(MY_ID, 9), 0, "R4 unused offset reads zero");
    req(0, 1, 0, 0, dir_addr(MY_ID, 0), 0, "R4 status after unused write");
    req(0, 1, 0, 0, dir_addr(MY_ID, 2), 0, "R4 mask after unused write");
    req(1, 1, 0, 0, dir_addr(MY_ID, 0), 32'h0000_0020, "R9 write wins over read");
    req(0, 1, 0, 0, dir_addr(MY_ID, 0), 0, "R9 read sees write");
    idle("R9 idle reads zero");
    req(1, 0, 1, 0, 32'h2, 32'h0, "R3 mask off no pulse");
    req(1, 0, 1, 0, 32'h2, 32'hFFFF_FFFF, "R3 mask all on pulse");
    idle("R9 drain");
    idle("R9 drain");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule